// File: doc/BRIEF.md
# Speech Section Repeat Controller

This block walks a speech equation: an ordered list of section descriptors held outside the block. Each descriptor names its kind (head, sound, silence or tail), a two-bit sample rate code, an LED on/off bit, a local repeat count and a length in sample periods. After a start pulse the controller fetches descriptors one at a time through a request/acknowledge handshake. It plays each section for its length in sample ticks, which it derives from the system clock. It repeats sound sections locally and loops the whole equation for a global repeat count.

Downstream logic (sample decoder, converter, LED flasher) follows the `sample_tick`, `mute` and `led_en` outputs. The `last_pass` flag exposes the final global pass for conditional program flow. A one-cycle `done` pulse marks normal completion, and `abort` drops everything at once.

Top module: `speech_seq_ctrl`

## Requirements
- R1: While reset is low and after its release, `sec_req`, `sample_tick`, `led_en`, `mute`, `last_pass` and `done` are all low until a start is accepted.
- R2: A start in idle raises `sec_req` with `sec_idx` = 0. `sec_idx` holds steady while `sec_req` waits for `sec_ack`. The descriptor is taken on the clock edge where both are high. Indices rise by one per section and return to 0 at the start of each global pass.
- R3: Within a section, `sample_tick` pulses once every DIV_R0/DIV_R1/DIV_R2/DIV_R3 clocks (defaults 750, 625, 500, 375, i.e. 4, 4.8, 6, 8 kHz from 3 MHz) for rate code 0/1/2/3. No tick occurs while a descriptor is being fetched.
- R4: One play of a section lasts `sec_len` ticks (17 bits, up to 0x1FFFF). A length of zero plays one tick.
- R5: A sound section (kind 1) plays `sec_reps` times (1 to 7, zero treated as one). Head (kind 0), silence (kind 2) and tail (kind 3) sections play once whatever their repeat field holds.
- R6: `mute` is high during every tick of a silence section and low during ticks of the other kinds.
- R7: `led_en` takes the descriptor's LED bit when it is accepted and keeps it until the next acceptance. It is low in idle.
- R8: A tail section ends a pass. The equation runs `gr_count` passes (1 to 16, zero treated as one).
- R9: `last_pass` is high through the whole final global pass and low in earlier passes and in idle.
- R10: After the final tail's last tick, `done` pulses high for exactly one cycle and the block returns to idle.
- R11: `abort` returns the block to idle at the next clock edge, with `led_en`, `sec_req`, `last_pass` and `sample_tick` low, and no `done` pulse follows.
- R12: A `start` while an equation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an equation when idle |
| abort | input | 1 | Stop at once, no done pulse |
| gr_count | input | 5 | Global pass count, 0 means 1 |
| sec_req | output | 1 | Descriptor fetch request |
| sec_idx | output | IDX_W (8) | Index of requested descriptor |
| sec_ack | input | 1 | Descriptor fields valid this cycle |
| sec_kind | input | 2 | 0 head, 1 sound, 2 silence, 3 tail |
| sec_rate | input | 2 | Sample rate code |
| sec_led | input | 1 | LED on during the section |
| sec_reps | input | 3 | Local repeat count, sound only |
| sec_len | input | LEN_W (17) | Section length in sample periods |
| sample_tick | output | 1 | One-clock sample strobe |
| led_en | output | 1 | LED enable for the current section |
| mute | output | 1 | Silence section playing |
| last_pass | output | 1 | Final global pass in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume the descriptor source acknowledges only while `sec_req` is high, holding `sec_ack` for one cycle and keeping the fields valid in that cycle. They also assume every divisor parameter is at least two, so ticks can never be adjacent. The bench's responder answers each request from a small table indexed by `sec_idx`, after a chosen wait, and drops `sec_ack` at once afterwards. All equations it plays end in a tail section within that table, with global counts no higher than sixteen.

// File: rtl/srr_pkg.sv
// Shared encodings for the speech section repeat controller.
// Assumes descriptor kind codes are fixed by the external equation store.
package srr_pkg;
    localparam int REP_W  = 3;
    localparam int GREP_W = 5;
    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        SEC_HEAD    = 2'd0,
        SEC_SOUND   = 2'd1,
        SEC_SILENCE = 2'd2,
        SEC_TAIL    = 2'd3
    } sec_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PLAY  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/srr_tick_gen.sv
// Sample-rate divider: emits a one-clock tick every DIVn clocks while run is
// high, n being the rate code. Assumes rate is stable while run is high and
// every divisor is at least 2.
module srr_tick_gen #(
    parameter int DIV0 = 750,
    parameter int DIV1 = 625,
    parameter int DIV2 = 500,
    parameter int DIV3 = 375
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [srr_pkg::RATE_W-1:0] rate,
    output logic                     tick
);
    localparam int M01   = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int M23   = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int DMAX  = (M01 > M23) ? M01 : M23;
    localparam int CNT_W = (DMAX > 2) ? $clog2(DMAX) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Select the terminal count for the current rate code.
    always_comb begin
        case (rate)
            2'd0:    limit = CNT_W'(DIV0 - 1);
            2'd1:    limit = CNT_W'(DIV1 - 1);
            2'd2:    limit = CNT_W'(DIV2 - 1);
            default: limit = CNT_W'(DIV3 - 1);
        endcase
    end

    assign tick = run && (cnt == limit);

    // Free-run the divider while playing, park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/srr_len_count.sv
// Section length counter: counts ticks and flags the tick that completes one
// play of len sample periods (zero length treated as one). Assumes len is
// stable while run is high.
module srr_len_count #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] span;

    assign span = (len == '0) ? LEN_W'(1) : len;
    assign last = tick && (cnt == span - LEN_W'(1));

    // Advance on each tick, wrap at the end of a play.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + LEN_W'(1);
        end
    end
endmodule

// File: rtl/speech_seq_ctrl.sv
// Speech section repeat controller. Fetches section descriptors in order,
// plays each for its length in sample ticks at its own rate, repeats sound
// sections locally and loops the equation on every tail for the global count.
// Assumes the descriptor source holds its fields valid in the sec_ack cycle
// and acknowledges only while sec_req is high.
module speech_seq_ctrl #(
    parameter int IDX_W  = 8,
    parameter int LEN_W  = 17,
    parameter int DIV_R0 = 750,
    parameter int DIV_R1 = 625,
    parameter int DIV_R2 = 500,
    parameter int DIV_R3 = 375
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [4:0]       gr_count,
    output logic             sec_req,
    output logic [IDX_W-1:0] sec_idx,
    input  logic             sec_ack,
    input  logic [1:0]       sec_kind,
    input  logic [1:0]       sec_rate,
    input  logic             sec_led,
    input  logic [2:0]       sec_reps,
    input  logic [LEN_W-1:0] sec_len,
    output logic             sample_tick,
    output logic             led_en,
    output logic             mute,
    output logic             last_pass,
    output logic             done
);
    import srr_pkg::*;

    seq_state_t               state;
    logic [IDX_W-1:0]         idx_q;
    sec_kind_t                kind_q;
    logic [RATE_W-1:0]        rate_q;
    logic [LEN_W-1:0]         len_q;
    logic                     led_q;
    logic [REP_W-1:0]         rep_left;
    logic [GREP_W-1:0]        pass_left;
    logic                     done_q;
    logic                     run;
    logic                     tick;
    logic                     play_end;
    logic [REP_W-1:0]         reps_eff;
    logic [GREP_W-1:0]        gr_eff;

    assign run       = (state == ST_PLAY);
    assign reps_eff  = (sec_kind == SEC_SOUND && sec_reps != '0) ? sec_reps : REP_W'(1);
    assign gr_eff    = (gr_count == '0) ? GREP_W'(1) : gr_count;

    srr_tick_gen #(
        .DIV0(DIV_R0), .DIV1(DIV_R1), .DIV2(DIV_R2), .DIV3(DIV_R3)
    ) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .rate (rate_q),
        .tick (tick)
    );

    srr_len_count #(.LEN_W(LEN_W)) len_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick),
        .len  (len_q),
        .last (play_end)
    );

    // Sequence fetches, plays, local repeats and global passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx_q     <= '0;
            kind_q    <= SEC_HEAD;
            rate_q    <= '0;
            len_q     <= '0;
            led_q     <= 1'b0;
            rep_left  <= '0;
            pass_left <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                state <= ST_IDLE;
                led_q <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            pass_left <= gr_eff;
                            idx_q     <= '0;
                            state     <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (sec_ack) begin
                            kind_q   <= sec_kind_t'(sec_kind);
                            rate_q   <= sec_rate;
                            len_q    <= sec_len;
                            led_q    <= sec_led;
                            rep_left <= reps_eff;
                            state    <= ST_PLAY;
                        end
                    end
                    ST_PLAY: begin
                        if (play_end) begin
                            if (rep_left > REP_W'(1)) begin
                                rep_left <= rep_left - REP_W'(1);
                            end else if (kind_q != SEC_TAIL) begin
                                idx_q <= idx_q + IDX_W'(1);
                                state <= ST_FETCH;
                            end else if (pass_left > GREP_W'(1)) begin
                                pass_left <= pass_left - GREP_W'(1);
                                idx_q     <= '0;
                                state     <= ST_FETCH;
                            end else begin
                                state  <= ST_IDLE;
                                led_q  <= 1'b0;
                                done_q <= 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sec_req     = (state == ST_FETCH);
    assign sec_idx     = idx_q;
    assign sample_tick = tick;
    assign led_en      = led_q;
    assign mute        = run && (kind_q == SEC_SILENCE);
    assign last_pass   = (state != ST_IDLE) && (pass_left == GREP_W'(1));
    assign done        = done_q;
endmodule

// File: rtl/speech_seq_ctrl_chk.sv
// Property checker for speech_seq_ctrl, attached by bind. Assumes the
// descriptor source obeys the handshake and all divisors are at least 2.
module speech_seq_ctrl_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             sec_req,
    input logic [IDX_W-1:0] sec_idx,
    input logic             sec_ack,
    input logic             sample_tick,
    input logic             led_en,
    input logic             mute,
    input logic             last_pass,
    input logic             done
);
    // Completion strobe lasts one cycle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion only appears with the block idle.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sec_req && !last_pass && !sample_tick));

    // Ticks never overlap a fetch, and never come back to back.
    assert_tick_not_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> !sec_req);
    assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick);

    // A pending request keeps its index.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_req && !sec_ack && !abort) |=> (sec_req && $stable(sec_idx)));

    // Silence is only flagged while playing.
    assert_mute_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> !sec_req);

    // Abort empties the block on the next edge.
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sec_req && !led_en && !last_pass && !sample_tick && !done && !mute));
endmodule

bind speech_seq_ctrl speech_seq_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .sec_req    (sec_req),
    .sec_idx    (sec_idx),
    .sec_ack    (sec_ack),
    .sample_tick(sample_tick),
    .led_en     (led_en),
    .mute       (mute),
    .last_pass  (last_pass),
    .done       (done)
);

// File: tb/speech_seq_ctrl_tb_top.sv
// Self-checking bench: a vector table of single-sound equations, then directed
// tests for reset, section kinds, slow acknowledge, abort and restart.
module speech_seq_ctrl_tb_top;
    localparam int IDX_W = 8;
    localparam int LEN_W = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic [4:0]       gr_count = '0;
    logic             sec_req;
    logic [IDX_W-1:0] sec_idx;
    logic             sec_ack = 1'b0;
    logic [1:0]       sec_kind;
    logic [1:0]       sec_rate;
    logic             sec_led;
    logic [2:0]       sec_reps;
    logic [LEN_W-1:0] sec_len;
    logic             sample_tick;
    logic             led_en;
    logic             mute;
    logic             last_pass;
    logic             done;

    always #5 clk = ~clk;

    speech_seq_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .gr_count(gr_count), .sec_req(sec_req), .sec_idx(sec_idx),
        .sec_ack(sec_ack), .sec_kind(sec_kind), .sec_rate(sec_rate),
        .sec_led(sec_led), .sec_reps(sec_reps), .sec_len(sec_len),
        .sample_tick(sample_tick), .led_en(led_en), .mute(mute),
        .last_pass(last_pass), .done(done)
    );

    // Descriptor store indexed by the requested section.
    logic [1:0]       t_kind [8];
    logic [1:0]       t_rate [8];
    logic             t_led  [8];
    logic [2:0]       t_reps [8];
    logic [LEN_W-1:0] t_len  [8];

    assign sec_kind = t_kind[sec_idx[2:0]];
    assign sec_rate = t_rate[sec_idx[2:0]];
    assign sec_led  = t_led[sec_idx[2:0]];
    assign sec_reps = t_reps[sec_idx[2:0]];
    assign sec_len  = t_len[sec_idx[2:0]];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Monitor state.
    int ack_wait = 0;
    int wait_n = 0;
    int n_tick, n_tick_last, n_mute, gap_err, led_err, mute_err, done_cyc, n_fetch;
    int since = 0;
    bit have_prev = 0;
    int fetch_log [16];
    logic [1:0] cur_rate, cur_kind;
    logic cur_led;

    function automatic int div_of(input logic [1:0] r);
        case (r)
            2'd0: return 750;
            2'd1: return 625;
            2'd2: return 500;
            default: return 375;
        endcase
    endfunction

    task automatic clear_mon();
        n_tick = 0; n_tick_last = 0; n_mute = 0; gap_err = 0; led_err = 0;
        mute_err = 0; done_cyc = 0; n_fetch = 0; have_prev = 0;
        for (int i = 0; i < 16; i++) fetch_log[i] = -1;
    endtask

    // Observe outputs and answer fetch requests, away from the active edge.
    always @(negedge clk) begin
        since = since + 1;
        if (sample_tick) begin
            n_tick++;
            if (last_pass) n_tick_last++;
            if (mute) n_mute++;
            if (mute != (cur_kind == 2'd2)) mute_err++;
            if (led_en != cur_led) led_err++;
            if (have_prev && since != div_of(cur_rate)) gap_err++;
            have_prev = 1;
            since = 0;
        end
        if (done) done_cyc++;
        if (sec_ack) begin
            sec_ack = 1'b0;
        end else if (sec_req) begin
            if (wait_n >= ack_wait) begin
                sec_ack = 1'b1;
                wait_n = 0;
                if (n_fetch < 16) fetch_log[n_fetch] = int'(sec_idx);
                n_fetch++;
                cur_rate = sec_rate;
                cur_kind = sec_kind;
                cur_led = sec_led;
                have_prev = 0;
            end else begin
                wait_n++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_sec(input int i, input logic [1:0] k, input logic [1:0] r,
                           input logic l, input logic [2:0] m, input int n);
        t_kind[i] = k; t_rate[i] = r; t_led[i] = l; t_reps[i] = m;
        t_len[i] = LEN_W'(n);
    endtask

    task automatic pulse_start(input logic [4:0] g);
        @(negedge clk);
        gr_count = g;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int c = 0;
        while (done_cyc == 0 && c < limit) begin
            @(negedge clk);
            c++;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    typedef struct packed {
        logic [1:0] rate;
        logic [7:0] len;
        logic [2:0] reps;
        logic [4:0] gr;
        logic       led;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 8'd2, 3'd1, 5'd1,  1'b1},
        '{2'd1, 8'd1, 3'd3, 5'd2,  1'b0},
        '{2'd2, 8'd3, 3'd0, 5'd0,  1'b1},
        '{2'd3, 8'd2, 3'd7, 5'd3,  1'b0},
        '{2'd2, 8'd0, 3'd2, 5'd16, 1'b1}
    };

    initial begin
        for (int i = 0; i < 8; i++) set_sec(i, 2'd3, 2'd3, 1'b0, 3'd0, 1);
        clear_mon();
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", {sec_req, sample_tick, led_en, mute, last_pass, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 after reset", {sec_req, sample_tick, led_en, mute, last_pass, done}, 0);

        // Vector table: sound section then tail, looped gr times.
        for (int v = 0; v < 5; v++) begin
            int per_pass;
            set_sec(0, 2'd1, VECS[v].rate, VECS[v].led, VECS[v].reps, int'(VECS[v].len));
            set_sec(1, 2'd3, 2'd3, ~VECS[v].led, 3'd5, 1);
            per_pass = eff(int'(VECS[v].len)) * eff(int'(VECS[v].reps)) + 1;
            clear_mon();
            pulse_start(VECS[v].gr);
            wait_done(40000);
            check("R4 R5 R8 tick total", n_tick, eff(int'(VECS[v].gr)) * per_pass);
            check("R9 ticks in last pass", n_tick_last, per_pass);
            check("R3 tick spacing errors", gap_err, 0);
            check("R7 led errors", led_err, 0);
            check("R10 done cycles", done_cyc, 1);
            check("R6 mute on sound", n_mute, 0);
            check("R7 R9 idle led/last", {led_en, last_pass}, 0);
        end

        // Section kinds, slow acknowledge, index order over two passes.
        set_sec(0, 2'd0, 2'd3, 1'b1, 3'd5, 1);
        set_sec(1, 2'd2, 2'd3, 1'b0, 3'd4, 3);
        set_sec(2, 2'd1, 2'd2, 1'b1, 3'd2, 1);
        set_sec(3, 2'd3, 2'd3, 1'b0, 3'd6, 1);
        ack_wait = 2;
        clear_mon();
        pulse_start(5'd2);
        wait_done(40000);
        ack_wait = 0;
        check("R5 head/silence/tail once", n_tick, 14);
        check("R6 mute ticks", n_mute, 6);
        check("R6 mute mismatches", mute_err, 0);
        check("R2 fetch count", n_fetch, 8);
        begin
            int bad = 0;
            for (int i = 0; i < 8; i++) if (fetch_log[i] != (i % 4)) bad++;
            check("R2 index order", bad, 0);
        end
        check("R3 spacing with slow ack", gap_err, 0);
        check("R9 last pass ticks", n_tick_last, 7);

        // Abort in mid section.
        set_sec(0, 2'd1, 2'd0, 1'b1, 3'd1, 4);
        set_sec(1, 2'd3, 2'd3, 1'b1, 3'd1, 1);
        clear_mon();
        pulse_start(5'd1);
        repeat (1000) @(negedge clk);
        check("R7 led during play", int'(led_en), 1);
        check("R9 last pass single", int'(last_pass), 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R11 idle after abort", {sec_req, led_en, last_pass, sample_tick}, 0);
        clear_mon();
        repeat (4000) @(negedge clk);
        check("R11 no ticks after abort", n_tick, 0);
        check("R11 no done after abort", done_cyc, 0);

        // Start while running.
        set_sec(0, 2'd1, 2'd3, 1'b0, 3'd1, 2);
        set_sec(1, 2'd3, 2'd3, 1'b0, 3'd1, 1);
        clear_mon();
        pulse_start(5'd1);
        repeat (300) @(negedge clk);
        pulse_start(5'd4);
        wait_done(10000);
        check("R12 fetches unchanged", n_fetch, 2);
        check("R12 ticks unchanged", n_tick, 3);
        check("R12 single done", done_cyc, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1950000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule